// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block runs a list of SPI master transfers without help from the host. The host fills a command table and a transmit table, then picks a start index and an end index and sets the run-enable. The sequencer then works through the entries in order. Each command byte sets the length of one transfer and how the slave-select behaves around it. The word received in each transfer goes into the receive slot that has the same index. After the last entry the run either stops or starts again at the start index.

Status flags report three events: a pass has finished, a mode fault has occurred, and a halt has been acknowledged. The flags are cleared by writing 1 to them. A completed-entry index shows how far the queue has got. A halt request, or a freeze input that has been enabled, parks the sequencer between two transfers. If the slave-select input is pulled low while the sequencer is the master, the run is aborted.

The state machine has seven states. IDLE waits for the run-enable. FETCH is the boundary between transfers: it loads the command and either starts a transfer or parks. HALTED holds the queue. SCK_LO and SCK_HI are the two phases of each bit. STORE writes the received word and moves the pointers. DELAY is an optional gap before the next entry. Transitions: IDLE→FETCH when enabled. FETCH→HALTED on a halt condition, otherwise FETCH→SCK_LO. HALTED→FETCH when the condition clears. SCK_LO→SCK_HI after a half period. SCK_HI→SCK_LO, or SCK_HI→STORE after the last bit. STORE→IDLE at the end of a run without wraparound, STORE→DELAY when the command asks for a gap, otherwise STORE→FETCH. DELAY→FETCH after the gap. From any state a mode fault goes to IDLE.

Top module: `qsq_top`

## Requirements
- R1: After reset, ss_n_o is 1, sck and mosi are 0, all three flags are 0, cmp_ptr is 0 and enabled is 0.
- R2: Entries from start_ptr to end_ptr run in ascending index order. Each entry is one mode-0 transfer, MSB first. Its length is cmd[4:0] bits: the value 0, or any value above 16, gives 16 bits. Bit k is taken from tx[n-1-k] of the transmit word. The n received bits are stored right-aligned and zero-extended in the receive slot that has the same index.
- R3: done_flag sets when the entry at end_ptr completes. Without wraparound, enabled then clears and the sequencer returns to idle with ss_n_o high.
- R4: With wrap_en set, the entry after end_ptr is start_ptr again. done_flag sets again on every pass, and enabled stays 1 until a pass ends with wrap_en low.
- R5: cmp_ptr holds the index of the last completed entry and changes only when an entry completes. While the first entry of a run is in progress it still shows 0 (after reset) or the final index of the previous run.
- R6: When enabled is 1 and ss_in_n is 0, then one cycle later fault_flag is 1, enabled is 0, ss_n_o is 1 and sck is 0. ss_in_n has no effect while enabled is 0.
- R7: A halt_req raised during a transfer lets that transfer complete. The sequencer then parks before the next entry, sets halt_ack, drives ss_n_o high and sck low, and starts nothing new. When halt_req drops, the run resumes with the next entry.
- R8: freeze parks the sequencer in the same way as halt_req, but only when freeze_en is 1. With freeze_en at 0, freeze has no effect.
- R9: Writing 1 to a bit of flag_clr clears that flag: bit 0 is done_flag, bit 1 is fault_flag, bit 2 is halt_ack. The other flags are left unchanged.
- R10: irq equals (halt_ie AND (halt_ack OR fault_flag)) OR (fin_ie AND done_flag).
- R11: When cmd[6] is 1, ss_n_o stays low from the end of that entry through the start of the next entry. When cmd[6] is 0, ss_n_o goes high between the two transfers.
- R12: When cmd[7] is 1 and another entry follows, exactly 4 extra idle cycles (parameter DLY_CYC) are inserted before the next entry starts.
- R13: When cmd[5] is 1, the transfer runs and cmp_ptr advances, but the receive slot keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_we | input | 1 | Host table write strobe |
| mem_sel_tx | input | 1 | Write target: 1 = transmit table, 0 = command table |
| mem_addr | input | 5 | Table write index |
| mem_wdata | input | 16 | Write data (command table takes bits 7:0) |
| rx_addr | input | 5 | Receive slot read index |
| rx_rdata | output | 16 | Receive slot contents |
| en_set | input | 1 | Pulse that sets the run-enable |
| start_ptr | input | 5 | First queue index |
| end_ptr | input | 5 | Last queue index |
| wrap_en | input | 1 | Wraparound enable |
| halt_req | input | 1 | Halt at the next entry boundary |
| freeze | input | 1 | External freeze request |
| freeze_en | input | 1 | Lets freeze act as a halt |
| halt_ie | input | 1 | Interrupt enable for halt and fault |
| fin_ie | input | 1 | Interrupt enable for finished |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| ss_in_n | input | 1 | Slave-select sense input |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n_o | output | 1 | Slave-select out, active low |
| enabled | output | 1 | Run-enable state |
| done_flag | output | 1 | Queue finished flag |
| fault_flag | output | 1 | Mode fault flag |
| halt_ack | output | 1 | Halt acknowledged flag |
| cmp_ptr | output | 5 | Index of the last completed entry |
| irq | output | 1 | Interrupt request |

## Verification
The fault response is due exactly one edge after ss_in_n is sampled low while enabled. The bench drives the pin at a falling edge and checks the port values at the next falling edge. done_flag, cmp_ptr and the receive slot all change at the edge that ends STORE, so the bench waits for done_flag and then reads them. halt_ack is due only after the current transfer has completed, so the bench checks cmp_ptr at that moment and again after a long wait. Gap lengths (R12) and select-line behaviour (R11) are measured as cycle-count differences and edge counts, which keeps these checks independent of the absolute transfer length.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HALTED,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_STORE,
        ST_DELAY
    } qsq_state_e;

    localparam int FLAG_FIN   = 0;
    localparam int FLAG_FAULT = 1;
    localparam int FLAG_HALT  = 2;
    localparam int NUM_FLAGS  = 3;

endpackage

// File: rtl/qsq_mem.sv
module qsq_mem #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic              host_sel_tx,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  seq_idx,
    output logic [CMD_W-1:0]  seq_cmd,
    output logic [DATA_W-1:0] seq_tx,
    input  logic              seq_rx_we,
    input  logic [DATA_W-1:0] seq_rx_word,
    input  logic [IDX_W-1:0]  host_rx_addr,
    output logic [DATA_W-1:0] host_rx_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CMD_W-1:0]  cmd_tab [DEPTH];
    logic [DATA_W-1:0] tx_tab  [DEPTH];
    logic [DATA_W-1:0] rx_tab  [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we && !host_sel_tx) begin
            cmd_tab[host_addr] <= host_wdata[CMD_W-1:0];
        end
        if (host_we && host_sel_tx) begin
            tx_tab[host_addr] <= host_wdata;
        end
        if (seq_rx_we) begin
            rx_tab[seq_idx] <= seq_rx_word;
        end
    end

    assign seq_cmd      = cmd_tab[seq_idx];
    assign seq_tx       = tx_tab[seq_idx];
    assign host_rx_data = rx_tab[host_rx_addr];

endmodule

// File: rtl/qsq_flags.sv
module qsq_flags
    import qsq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic [NUM_FLAGS-1:0] clr_vec,
    input  logic                 halt_ie,
    input  logic                 fin_ie,
    output logic [NUM_FLAGS-1:0] flag_q,
    output logic                 irq
);
    // A set event in the same cycle wins over a clear.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else begin
                flag_q[g] <= set_vec[g] | (flag_q[g] & ~clr_vec[g]);
            end
        end
    end

    assign irq = (halt_ie & (flag_q[FLAG_HALT] | flag_q[FLAG_FAULT]))
               | (fin_ie & flag_q[FLAG_FIN]);

endmodule

// File: rtl/qsq_seq.sv
module qsq_seq
    import qsq_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 16,
    parameter int CMD_W    = 8,
    parameter int SCK_HALF = 2,
    parameter int DLY_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic [IDX_W-1:0]  start_ptr,
    input  logic [IDX_W-1:0]  end_ptr,
    input  logic              wrap_en,
    input  logic              halt_req,
    input  logic              freeze,
    input  logic              freeze_en,
    input  logic              ss_in_n,
    input  logic              miso,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] tx_word,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n_o,
    output logic              enabled,
    output logic [IDX_W-1:0]  cmp_ptr,
    output logic              set_fin,
    output logic              set_fault,
    output logic              set_halt
);
    localparam int LEN_W       = $clog2(DATA_W) + 1;
    localparam int BC_W        = $clog2(DATA_W + 1);
    localparam int HC_W        = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int DC_W        = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
    localparam int BIT_NOSTORE = CMD_W - 3;
    localparam int BIT_KEEP    = CMD_W - 2;
    localparam int BIT_DELAY   = CMD_W - 1;

    qsq_state_e state, state_nx;

    logic              en_q;
    logic [IDX_W-1:0]  ptr;
    logic [IDX_W-1:0]  cptr;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [BC_W-1:0]   bits_left;
    logic [HC_W-1:0]   hcnt;
    logic [DC_W-1:0]   dcnt;
    logic              keep_q;
    logic              dly_q;
    logic              nostore_q;
    logic              hold_q;
    logic              sel_on;

    logic              fault;
    logic              halt_c;
    logic              last;
    logic              half_end;
    logic [LEN_W-1:0]  len_f;
    logic [BC_W-1:0]   nbits;

    assign fault    = en_q && !ss_in_n;
    assign halt_c   = halt_req || (freeze && freeze_en);
    assign last     = (ptr == end_ptr);
    assign half_end = (hcnt == HC_W'(SCK_HALF - 1));
    assign len_f    = cmd[LEN_W-1:0];

    always_comb begin
        if (len_f == '0 || int'(len_f) > DATA_W) begin
            nbits = BC_W'(DATA_W);
        end else begin
            nbits = BC_W'(len_f);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_q) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = halt_c ? ST_HALTED : ST_SCK_LO;
            ST_HALTED: if (!halt_c) state_nx = ST_FETCH;
            ST_SCK_LO: if (half_end) state_nx = ST_SCK_HI;
            ST_SCK_HI: begin
                if (half_end) begin
                    state_nx = (bits_left == BC_W'(1)) ? ST_STORE : ST_SCK_LO;
                end
            end
            ST_STORE: begin
                if (last && !wrap_en)   state_nx = ST_IDLE;
                else if (dly_q)         state_nx = ST_DELAY;
                else                    state_nx = ST_FETCH;
            end
            ST_DELAY:  if (dcnt == DC_W'(DLY_CYC - 1)) state_nx = ST_FETCH;
            default:   state_nx = ST_IDLE;
        endcase
        if (fault) state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs decoded from the state
    always_comb begin
        sck      = 1'b0;
        mosi     = 1'b0;
        sel_on   = 1'b0;
        rx_we    = 1'b0;
        set_fin  = 1'b0;
        set_halt = 1'b0;
        unique case (state)
            ST_SCK_LO: begin
                sel_on = 1'b1;
                mosi   = tx_sh[DATA_W-1];
            end
            ST_SCK_HI: begin
                sel_on = 1'b1;
                sck    = 1'b1;
                mosi   = tx_sh[DATA_W-1];
            end
            ST_STORE: begin
                sel_on  = 1'b1;
                rx_we   = !fault && !nostore_q;
                set_fin = !fault && last;
            end
            ST_FETCH: begin
                sel_on   = hold_q;
                set_halt = !fault && halt_c;
            end
            ST_DELAY:  sel_on = hold_q;
            default: ;
        endcase
    end

    assign ss_n_o    = ~sel_on;
    assign set_fault = fault;
    assign cur_idx   = ptr;
    assign rx_word   = rx_sh;
    assign enabled   = en_q;
    assign cmp_ptr   = cptr;

    // pointers, shifters and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            ptr       <= '0;
            cptr      <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            hcnt      <= '0;
            dcnt      <= '0;
            keep_q    <= 1'b0;
            dly_q     <= 1'b0;
            nostore_q <= 1'b0;
            hold_q    <= 1'b0;
        end else if (fault) begin
            en_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (en_set) en_q <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    hold_q <= 1'b0;
                    if (en_q) ptr <= start_ptr;
                end
                ST_FETCH: begin
                    if (halt_c) begin
                        hold_q <= 1'b0;
                    end else begin
                        tx_sh     <= tx_word << (DATA_W - int'(nbits));
                        rx_sh     <= '0;
                        bits_left <= nbits;
                        hcnt      <= '0;
                        keep_q    <= cmd[BIT_KEEP];
                        dly_q     <= cmd[BIT_DELAY];
                        nostore_q <= cmd[BIT_NOSTORE];
                    end
                end
                ST_SCK_LO: begin
                    if (half_end) begin
                        hcnt  <= '0;
                        rx_sh <= {rx_sh[DATA_W-2:0], miso};
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_SCK_HI: begin
                    if (half_end) begin
                        hcnt      <= '0;
                        tx_sh     <= tx_sh << 1;
                        bits_left <= bits_left - 1'b1;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_STORE: begin
                    cptr   <= ptr;
                    hold_q <= keep_q;
                    dcnt   <= '0;
                    if (last) begin
                        if (wrap_en) begin
                            ptr <= start_ptr;
                        end else begin
                            en_q   <= 1'b0;
                            hold_q <= 1'b0;
                        end
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_DELAY: dcnt <= dcnt + 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qsq_top.sv
module qsq_top
    import qsq_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 16,
    parameter int CMD_W    = 8,
    parameter int SCK_HALF = 2,
    parameter int DLY_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic              mem_sel_tx,
    input  logic [IDX_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [IDX_W-1:0]  rx_addr,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              en_set,
    input  logic [IDX_W-1:0]  start_ptr,
    input  logic [IDX_W-1:0]  end_ptr,
    input  logic              wrap_en,
    input  logic              halt_req,
    input  logic              freeze,
    input  logic              freeze_en,
    input  logic              halt_ie,
    input  logic              fin_ie,
    input  logic [2:0]        flag_clr,
    input  logic              ss_in_n,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n_o,
    output logic              enabled,
    output logic              done_flag,
    output logic              fault_flag,
    output logic              halt_ack,
    output logic [IDX_W-1:0]  cmp_ptr,
    output logic              irq
);
    logic [IDX_W-1:0]     cur_idx;
    logic [CMD_W-1:0]     cur_cmd;
    logic [DATA_W-1:0]    cur_tx;
    logic                 rx_we;
    logic [DATA_W-1:0]    rx_word;
    logic                 set_fin, set_fault, set_halt;
    logic [NUM_FLAGS-1:0] set_vec, flag_q;

    qsq_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_mem (
        .clk          (clk),
        .host_we      (mem_we),
        .host_sel_tx  (mem_sel_tx),
        .host_addr    (mem_addr),
        .host_wdata   (mem_wdata),
        .seq_idx      (cur_idx),
        .seq_cmd      (cur_cmd),
        .seq_tx       (cur_tx),
        .seq_rx_we    (rx_we),
        .seq_rx_word  (rx_word),
        .host_rx_addr (rx_addr),
        .host_rx_data (rx_rdata)
    );

    qsq_seq #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
        .SCK_HALF(SCK_HALF), .DLY_CYC(DLY_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .start_ptr (start_ptr),
        .end_ptr   (end_ptr),
        .wrap_en   (wrap_en),
        .halt_req  (halt_req),
        .freeze    (freeze),
        .freeze_en (freeze_en),
        .ss_in_n   (ss_in_n),
        .miso      (miso),
        .cmd       (cur_cmd),
        .tx_word   (cur_tx),
        .cur_idx   (cur_idx),
        .rx_we     (rx_we),
        .rx_word   (rx_word),
        .sck       (sck),
        .mosi      (mosi),
        .ss_n_o    (ss_n_o),
        .enabled   (enabled),
        .cmp_ptr   (cmp_ptr),
        .set_fin   (set_fin),
        .set_fault (set_fault),
        .set_halt  (set_halt)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[FLAG_FIN]   = set_fin;
        set_vec[FLAG_FAULT] = set_fault;
        set_vec[FLAG_HALT]  = set_halt;
    end

    qsq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (flag_clr),
        .halt_ie (halt_ie),
        .fin_ie  (fin_ie),
        .flag_q  (flag_q),
        .irq     (irq)
    );

    assign done_flag  = flag_q[FLAG_FIN];
    assign fault_flag = flag_q[FLAG_FAULT];
    assign halt_ack   = flag_q[FLAG_HALT];

endmodule

// File: rtl/qsq_chk.sv
module qsq_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ss_in_n,
    input logic             enabled,
    input logic             fault_flag,
    input logic             done_flag,
    input logic             halt_ack,
    input logic             halt_ie,
    input logic             irq,
    input logic             ss_n_o,
    input logic             sck,
    input logic [IDX_W-1:0] cmp_ptr,
    input logic [IDX_W-1:0] end_ptr
);
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !ss_in_n) |=> (!enabled && fault_flag)); // R6

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (ss_n_o && !sck)); // R3

    AST_CPTR_HOLD_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> $stable(cmp_ptr)); // R5

    AST_FIN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (cmp_ptr == end_ptr)); // R3

    AST_HALT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_ack) |-> (ss_n_o && !sck)); // R7

    AST_HALT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_ie && halt_ack) |-> irq); // R10

endmodule

bind qsq_top qsq_chk #(.IDX_W(IDX_W)) u_qsq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_in_n    (ss_in_n),
    .enabled    (enabled),
    .fault_flag (fault_flag),
    .done_flag  (done_flag),
    .halt_ack   (halt_ack),
    .halt_ie    (halt_ie),
    .irq        (irq),
    .ss_n_o     (ss_n_o),
    .sck        (sck),
    .cmp_ptr    (cmp_ptr),
    .end_ptr    (end_ptr)
);

// File: tb/tb_qsq_top.sv
module tb_qsq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DLY       = 4;
    localparam int LIMIT     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_we = 1'b0, mem_sel_tx = 1'b0;
    logic [4:0]  mem_addr = '0, rx_addr = '0, start_ptr = '0, end_ptr = '0;
    logic [15:0] mem_wdata = '0;
    logic [15:0] rx_rdata;
    logic        en_set = 1'b0, wrap_en = 1'b0, halt_req = 1'b0;
    logic        freeze = 1'b0, freeze_en = 1'b0, halt_ie = 1'b0, fin_ie = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic        ss_in_n = 1'b1;
    logic        miso;
    logic        sck, mosi, ss_n_o, enabled, done_flag, fault_flag, halt_ack, irq;
    logic [4:0]  cmp_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    int ss_rises = 0;
    logic ss_prev = 1'b1;
    logic [15:0] txv [32];
    logic [7:0]  cmdv [32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // inverted loopback slave: received bit = NOT transmitted bit
    assign miso = ~mosi;

    always @(negedge clk) begin
        if (!ss_prev && ss_n_o) ss_rises++;
        ss_prev = ss_n_o;
    end

    qsq_top dut (
        .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_sel_tx(mem_sel_tx),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_addr(rx_addr),
        .rx_rdata(rx_rdata), .en_set(en_set), .start_ptr(start_ptr),
        .end_ptr(end_ptr), .wrap_en(wrap_en), .halt_req(halt_req),
        .freeze(freeze), .freeze_en(freeze_en), .halt_ie(halt_ie),
        .fin_ie(fin_ie), .flag_clr(flag_clr), .ss_in_n(ss_in_n), .miso(miso),
        .sck(sck), .mosi(mosi), .ss_n_o(ss_n_o), .enabled(enabled),
        .done_flag(done_flag), .fault_flag(fault_flag), .halt_ack(halt_ack),
        .cmp_ptr(cmp_ptr), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [7:0] c);
        int f = int'(c[4:0]);
        return (f == 0 || f > 16) ? 16 : f;
    endfunction

    function automatic logic [15:0] exp_rx(input logic [15:0] t, input logic [7:0] c);
        logic [15:0] m = (len_of(c) == 16) ? 16'hFFFF : 16'((1 << len_of(c)) - 1);
        return ~t & m;
    endfunction

    task automatic load(input int idx, input logic [7:0] c, input logic [15:0] t);
        cmdv[idx] = c;
        txv[idx]  = t;
        @(negedge clk);
        mem_we = 1'b1; mem_sel_tx = 1'b0; mem_addr = 5'(idx); mem_wdata = {8'h00, c};
        @(negedge clk);
        mem_sel_tx = 1'b1; mem_wdata = t;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic go(input int s, input int e);
        start_ptr = 5'(s);
        end_ptr   = 5'(e);
        en_set    = 1'b1;
        @(negedge clk);
        en_set    = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
    endtask

    // which: 0 done_flag, 1 halt_ack, 2 sck high
    task automatic wait_for(input int which, input string req, output int cyc);
        logic hit;
        cyc = 0;
        for (int i = 0; i < LIMIT; i++) begin
            case (which)
                0: hit = done_flag;
                1: hit = halt_ack;
                default: hit = sck;
            endcase
            if (hit) return;
            @(negedge clk);
            cyc++;
        end
        chk(req, "timeout waiting for event", 0, 1);
    endtask

    task automatic rx_chk(input string req, input int idx, input logic [15:0 ] exp);
        rx_addr = 5'(idx);
        #1;
        chk(req, $sformatf("rx slot %0d", idx), {16'h0, rx_rdata}, {16'h0, exp});
    endtask

    task automatic t_reset();
        chk("R1", "ss_n_o", ss_n_o, 1);
        chk("R1", "sck", sck, 0);
        chk("R1", "mosi", mosi, 0);
        chk("R1", "flags", {done_flag, fault_flag, halt_ack}, 0);
        chk("R1", "cmp_ptr", cmp_ptr, 0);
        chk("R1", "enabled", enabled, 0);
    endtask

    task automatic t_basic();
        int c;
        load(0, 8'h00, 16'hA5C3);
        load(1, 8'h08, 16'h1234);
        load(2, 8'h05, 16'hFFEA);
        load(3, 8'h1C, 16'h0F0F);
        fin_ie = 1'b1;
        go(0, 3);
        wait_for(2, "R5", c);
        chk("R5", "cmp_ptr during first entry after reset", cmp_ptr, 0);
        wait_for(0, "R3", c);
        @(negedge clk);
        chk("R3", "done_flag", done_flag, 1);
        chk("R3", "enabled cleared", enabled, 0);
        chk("R3", "ss_n_o idle", ss_n_o, 1);
        chk("R5", "cmp_ptr at end", cmp_ptr, 3);
        chk("R10", "irq from finished", irq, 1);
        for (int i = 0; i < 4; i++) rx_chk("R2", i, exp_rx(txv[i], cmdv[i]));
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R9", "done_flag cleared", done_flag, 0);
        chk("R10", "irq after clear", irq, 0);
        fin_ie = 1'b0;
    endtask

    task automatic t_prev_queue();
        int c;
        load(5, 8'h06, 16'h0029);
        load(6, 8'h0A, 16'h02C1);
        go(5, 6);
        wait_for(2, "R5", c);
        chk("R5", "cmp_ptr holds previous run end", cmp_ptr, 3);
        wait_for(0, "R5", c);
        chk("R5", "cmp_ptr at new end", cmp_ptr, 6);
        rx_chk("R2", 5, exp_rx(txv[5], cmdv[5]));
        rx_chk("R2", 6, exp_rx(txv[6], cmdv[6]));
        clear_all();
    endtask

    task automatic t_nostore();
        int c;
        load(1, 8'h28, 16'h00FF);
        go(1, 1);
        wait_for(0, "R13", c);
        chk("R13", "cmp_ptr advanced", cmp_ptr, 1);
        rx_chk("R13", 1, exp_rx(16'h1234, 8'h08));
        clear_all();
    endtask

    task automatic t_wrap();
        int c;
        load(8, 8'h04, 16'h0009);
        load(9, 8'h04, 16'h0006);
        wrap_en = 1'b1;
        go(8, 9);
        wait_for(0, "R4", c);
        clear_all();
        chk("R4", "enabled stays during wrap", enabled, 1);
        wait_for(0, "R4", c);
        chk("R4", "done_flag on second pass", done_flag, 1);
        wrap_en = 1'b0;
        clear_all();
        wait_for(0, "R4", c);
        @(negedge clk);
        chk("R4", "stopped after unwrapped pass", enabled, 0);
        chk("R4", "cmp_ptr", cmp_ptr, 9);
        rx_chk("R4", 8, exp_rx(txv[8], cmdv[8]));
        clear_all();
    endtask

    task automatic t_halt();
        int c;
        for (int i = 10; i < 14; i++) load(i, 8'h08, 16'(16'h3C00 + i * 16'h0111));
        halt_ie = 1'b1;
        go(10, 13);
        wait_for(2, "R7", c);
        halt_req = 1'b1;
        wait_for(1, "R7", c);
        chk("R7", "entry in progress completed", cmp_ptr, 10);
        chk("R7", "ss_n_o parked", ss_n_o, 1);
        chk("R10", "irq from halt", irq, 1);
        repeat (40) @(negedge clk);
        chk("R7", "no new entry while halted", cmp_ptr, 10);
        chk("R7", "sck quiet while halted", sck, 0);
        halt_req = 1'b0;
        wait_for(0, "R7", c);
        chk("R7", "resumed to end", cmp_ptr, 13);
        for (int i = 11; i < 14; i++) rx_chk("R7", i, exp_rx(txv[i], cmdv[i]));
        clear_all();
        chk("R10", "irq low after clear", irq, 0);
        halt_ie = 1'b0;
    endtask

    task automatic t_freeze();
        int c;
        load(14, 8'h03, 16'h0005);
        load(15, 8'h03, 16'h0002);
        freeze = 1'b1;
        freeze_en = 1'b0;
        go(14, 15);
        wait_for(0, "R8", c);
        chk("R8", "freeze ignored without enable", halt_ack, 0);
        chk("R8", "cmp_ptr", cmp_ptr, 15);
        clear_all();
        freeze_en = 1'b1;
        go(14, 15);
        wait_for(1, "R8", c);
        chk("R8", "halt_ack from freeze", halt_ack, 1);
        repeat (20) @(negedge clk);
        chk("R8", "no entry done while frozen", done_flag, 0);
        freeze = 1'b0;
        wait_for(0, "R8", c);
        chk("R8", "run finished after unfreeze", cmp_ptr, 15);
        freeze_en = 1'b0;
        clear_all();
    endtask

    task automatic t_select();
        int c;
        load(16, 8'h44, 16'h000A);
        load(17, 8'h44, 16'h0005);
        load(18, 8'h04, 16'h000C);
        ss_rises = 0;
        go(16, 18);
        wait_for(0, "R11", c);
        @(negedge clk);
        chk("R11", "select rises with keep bit", ss_rises, 1);
        clear_all();
        load(16, 8'h04, 16'h000A);
        load(17, 8'h04, 16'h0005);
        ss_rises = 0;
        go(16, 18);
        wait_for(0, "R11", c);
        @(negedge clk);
        chk("R11", "select rises without keep bit", ss_rises, 3);
        clear_all();
    endtask

    task automatic t_delay();
        int c0, c1;
        load(20, 8'h04, 16'h0003);
        load(21, 8'h04, 16'h0009);
        go(20, 21);
        wait_for(0, "R12", c0);
        clear_all();
        load(20, 8'h84, 16'h0003);
        go(20, 21);
        wait_for(0, "R12", c1);
        chk("R12", "extra cycles from delay bit", c1 - c0, DLY);
        clear_all();
        load(21, 8'h84, 16'h0009);
        load(20, 8'h04, 16'h0003);
        go(20, 21);
        wait_for(0, "R12", c1);
        chk("R12", "no gap after last entry", c1, c0);
        clear_all();
    endtask

    task automatic t_fault();
        int c;
        ss_in_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", "no fault while disabled", fault_flag, 0);
        ss_in_n = 1'b1;
        halt_ie = 1'b1;
        go(0, 3);
        wait_for(2, "R6", c);
        ss_in_n = 1'b0;
        @(negedge clk);
        chk("R6", "fault_flag", fault_flag, 1);
        chk("R6", "enabled cleared", enabled, 0);
        chk("R6", "ss_n_o released", ss_n_o, 1);
        chk("R6", "sck idle", sck, 0);
        chk("R10", "irq from fault", irq, 1);
        ss_in_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R6", "queue stays aborted", done_flag, 0);
        flag_clr = 3'b010;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R9", "fault_flag cleared", fault_flag, 0);
        halt_ie = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prev_queue();
        t_nostore();
        t_wrap();
        t_halt();
        t_freeze();
        t_select();
        t_delay();
        t_fault();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished run");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule